// File: doc/BRIEF.md
# Dual-Register Serial-to-Parallel Expander

The expander collects a serial bit stream into an 8-stage shift register and, on command, copies the collected word into an 8-bit holding register that drives the parallel outputs. The shift stage and the holding stage each have their own strobe and their own active-low clear. All five control and data pins are treated as asynchronous. They pass through two-flop synchronizers into a single system clock domain, and the two strobes are turned into one-cycle events by small edge-detecting state machines.

Each edge detector has two states: `PIN_LOW` and `PIN_HIGH`. The transition `PIN_LOW -> PIN_HIGH` is taken when the synchronized strobe is seen high, and it emits the event pulse. The transition `PIN_HIGH -> PIN_LOW` is taken when the strobe is seen low, and it emits nothing. A last-stage tap (`cascade_out`) lets several expanders be chained. Because the holding register copies the shift contents present before a simultaneous shift, tying the two strobes together keeps the parallel word exactly one shift behind.

Top module: `sipo_expander`

## Requirements
- R1: After system reset, `par_out` is 8'h00 and `cascade_out` is 0.
- R2: On a rising edge of `shift_strobe`, shift stage 0 takes `data_in` and stage i takes stage i-1. `par_out[0]` maps stage 0 and `par_out[7]` maps stage 7, so after eight shifts the first bit shifted in appears on `par_out[7]`.
- R3: A falling edge of `shift_strobe` leaves the shift contents unchanged.
- R4: While `shift_clear_n` is low, all shift stages are zero and rising edges of `shift_strobe` are ignored.
- R5: On a rising edge of `latch_strobe`, with `latch_clear_n` high, `par_out` takes the current shift contents.
- R6: While `latch_clear_n` is low, `par_out` is zero and rising edges of `latch_strobe` are ignored. The shift contents are not disturbed by this clear.
- R7: `cascade_out` always equals shift stage 7, independent of the holding register.
- R8: When both strobes rise together, `par_out` takes the shift contents from before that shift, so the shift register stays one event ahead.
- R9: A change on any pin reaches the outputs at the third rising system-clock edge after the pin change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| data_in | input | 1 | Serial data bit |
| shift_strobe | input | 1 | Shift event on rising edge |
| latch_strobe | input | 1 | Transfer event on rising edge |
| shift_clear_n | input | 1 | Active-low clear of the shift stages |
| latch_clear_n | input | 1 | Active-low clear of the holding register |
| par_out | output | 8 | Holding register contents, bit 0 = first stage |
| cascade_out | output | 1 | Last shift stage, for chaining |

## Verification
The embedded assertions check, on every cycle, the following rules:
- a shift event moves each stage up by one and loads `data_in` into stage 0;
- the shift stages hold when there is no event;
- each clear zeroes its own register on the next cycle;
- a transfer copies the shift contents, including on cycles where both events coincide;
- a holding-register clear leaves idle shift stages untouched;
- a strobe never produces two events in a row.

Only the bench scenarios show behaviour seen end to end at the pins: the bit ordering on `par_out` after a full word, a falling strobe having no effect, an event masked by a clear, and the exact three-edge latency from pin to output.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    // Two-state view of a synchronized strobe pin
    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;

    // Pin indices inside the synchronizer bank
    localparam int PIN_DATA  = 0;
    localparam int PIN_SHIFT = 1;
    localparam int PIN_LATCH = 2;
    localparam int PIN_SCLR  = 3;
    localparam int PIN_LCLR  = 4;
    localparam int PIN_COUNT = 5;

endpackage

// File: rtl/sipo_sync.sv
module sipo_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] flops;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flops <= {STAGES{RESET_VAL}};
        end else begin
            flops <= {flops[STAGES-2:0], d};
        end
    end

    assign q = flops[STAGES-1];

endmodule

// File: rtl/sipo_edge_fsm.sv
module sipo_edge_fsm
    import sipo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    pin_state_e state_q;
    pin_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_LOW:  if (level)  state_d = PIN_HIGH;
            PIN_HIGH: if (!level) state_d = PIN_LOW;
            default:  state_d = PIN_LOW;
        endcase
    end

    // Outputs: the event fires only on the PIN_LOW -> PIN_HIGH transition
    always_comb begin
        rise = 1'b0;
        unique case (state_q)
            PIN_LOW:  rise = level;
            PIN_HIGH: rise = 1'b0;
            default:  rise = 1'b0;
        endcase
    end

    // R2: one pulse per rising edge, never two events back to back
    assert_single_event_R2: assert property (
        @(posedge clk) disable iff (!rst_n) rise |=> !rise
    );

endmodule

// File: rtl/sipo_shift_reg.sv
module sipo_shift_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             step,
    input  logic             din,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (!clr_n) begin
            q <= '0;
        end else if (step) begin
            q <= {q[WIDTH-2:0], din};
        end
    end

    assert_clear_empties_R4: assert property (
        @(posedge clk) disable iff (!rst_n) !clr_n |=> (q == '0)
    );

    assert_shift_moves_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (clr_n && step) |=> (q[WIDTH-1:1] == $past(q[WIDTH-2:0])) && (q[0] == $past(din))
    );

    assert_idle_holds_R3: assert property (
        @(posedge clk) disable iff (!rst_n) (clr_n && !step) |=> $stable(q)
    );

endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             load,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (!clr_n) begin
            q <= '0;
        end else if (load) begin
            q <= src;
        end
    end

    assert_load_copies_R5: assert property (
        @(posedge clk) disable iff (!rst_n) (clr_n && load) |=> (q == $past(src))
    );

    assert_clear_empties_R6: assert property (
        @(posedge clk) disable iff (!rst_n) !clr_n |=> (q == '0)
    );

endmodule

// File: rtl/sipo_expander.sv
module sipo_expander
    import sipo_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_in,
    input  logic             shift_strobe,
    input  logic             latch_strobe,
    input  logic             shift_clear_n,
    input  logic             latch_clear_n,
    output logic [WIDTH-1:0] par_out,
    output logic             cascade_out
);

    // Clears idle high, everything else idles low
    localparam logic [PIN_COUNT-1:0] SYNC_RST = (1 << PIN_SCLR) | (1 << PIN_LCLR);
    localparam int NUM_EDGES = 2;

    logic [PIN_COUNT-1:0] pin_raw;
    logic [PIN_COUNT-1:0] pin_s;
    logic [NUM_EDGES-1:0] ev;
    logic [WIDTH-1:0]     shift_q;

    assign pin_raw = {latch_clear_n, shift_clear_n, latch_strobe, shift_strobe, data_in};

    genvar gi;
    generate
        for (gi = 0; gi < PIN_COUNT; gi++) begin : g_sync
            sipo_sync #(
                .STAGES    (SYNC_STAGES),
                .RESET_VAL (SYNC_RST[gi])
            ) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (pin_raw[gi]),
                .q     (pin_s[gi])
            );
        end
        // ev[0]: shift event, ev[1]: latch event
        for (gi = 0; gi < NUM_EDGES; gi++) begin : g_edge
            sipo_edge_fsm u_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .level (pin_s[PIN_SHIFT + gi]),
                .rise  (ev[gi])
            );
        end
    endgenerate

    sipo_shift_reg #(.WIDTH(WIDTH)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (pin_s[PIN_SCLR]),
        .step  (ev[0]),
        .din   (pin_s[PIN_DATA]),
        .q     (shift_q)
    );

    sipo_hold_reg #(.WIDTH(WIDTH)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (pin_s[PIN_LCLR]),
        .load  (ev[1]),
        .src   (shift_q),
        .q     (par_out)
    );

    assign cascade_out = shift_q[WIDTH-1];

    // R8: a coincident shift and transfer captures the pre-shift word
    assert_tied_lags_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ev[0] && ev[1] && pin_s[PIN_LCLR] && pin_s[PIN_SCLR])
            |=> (par_out == $past(shift_q)) && (par_out != shift_q || $past(shift_q) == shift_q)
    );

    // R6: clearing the holding register leaves idle shift stages untouched
    assert_hold_clear_spares_shift_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!pin_s[PIN_LCLR] && pin_s[PIN_SCLR] && !ev[0]) |=> $stable(shift_q)
    );

endmodule

// File: tb/sipo_expander_bench.sv
module sipo_expander_bench;

    typedef struct {
        logic [7:0] par;
        logic       chain;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_in = 1'b0;
    logic       shift_strobe = 1'b0;
    logic       latch_strobe = 1'b0;
    logic       shift_clear_n = 1'b1;
    logic       latch_clear_n = 1'b1;
    logic [7:0] par_out;
    logic       cascade_out;

    exp_t       sb_q[$];
    exp_t       cur;
    int         vectors = 0;
    int         miscompares = 0;
    bit         finished = 1'b0;
    logic [7:0] m_shift = 8'h00;
    logic [7:0] m_store = 8'h00;

    always #2.5 clk = ~clk;

    sipo_expander u_sipo_expander (
        .clk           (clk),
        .rst_n         (rst_n),
        .data_in       (data_in),
        .shift_strobe  (shift_strobe),
        .latch_strobe  (latch_strobe),
        .shift_clear_n (shift_clear_n),
        .latch_clear_n (latch_clear_n),
        .par_out       (par_out),
        .cascade_out   (cascade_out)
    );

    // Monitor: pops one expectation per falling edge and compares
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            vectors++;
            if (par_out !== cur.par || cascade_out !== cur.chain) begin
                miscompares++;
                $display("FAIL %s: par_out=%h expected %h, cascade_out=%b expected %b",
                         cur.tag, par_out, cur.par, cascade_out, cur.chain);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input string tag);
        sb_q.push_back('{m_store, m_shift[7], tag});
    endtask

    task automatic shift_bit(input logic b, input string tag);
        data_in = b;
        tick(1);
        shift_strobe = 1'b1;
        tick(4);
        if (shift_clear_n) m_shift = {m_shift[6:0], b};
        push(tag);
        shift_strobe = 1'b0;
        tick(4);
        push({tag, " R3 falling edge"});
    endtask

    task automatic latch_word(input string tag);
        latch_strobe = 1'b1;
        tick(4);
        if (latch_clear_n) m_store = m_shift;
        push(tag);
        latch_strobe = 1'b0;
        tick(4);
    endtask

    task automatic tied_pulse(input logic b, input string tag);
        data_in = b;
        tick(1);
        shift_strobe = 1'b1;
        latch_strobe = 1'b1;
        tick(4);
        m_store = m_shift;
        m_shift = {m_shift[6:0], b};
        push(tag);
        shift_strobe = 1'b0;
        latch_strobe = 1'b0;
        tick(4);
    endtask

    initial begin
        logic [7:0] pat;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        push("R1 reset state");
        tick(1);

        // R2 / R7: shift a full word, check cascade bit after each shift
        pat = 8'b1011_0010;
        for (int k = 7; k >= 0; k--) shift_bit(pat[k], "R2 R7 shift step");
        latch_word("R5 R2 transfer full word, first bit on bit 7");

        // Second pattern with a single marked first bit
        for (int k = 0; k < 8; k++) shift_bit(k == 0, "R2 R7 walking one");
        latch_word("R5 R2 walking one lands on bit 7");

        // R4: shift clear masks events
        shift_clear_n = 1'b0;
        tick(4);
        m_shift = 8'h00;
        push("R4 shift clear empties stages");
        shift_bit(1'b1, "R4 shift ignored under clear");
        shift_clear_n = 1'b1;
        tick(4);
        latch_word("R4 R5 transfer after clear");

        // R6: holding clear masks transfer, shift data survives
        for (int k = 0; k < 4; k++) shift_bit(1'b1, "R7 refill");
        latch_word("R5 transfer 0F");
        latch_clear_n = 1'b0;
        tick(4);
        m_store = 8'h00;
        push("R6 hold clear empties par_out");
        shift_bit(1'b0, "R6 shift during hold clear");
        latch_word("R6 transfer ignored under clear");
        latch_clear_n = 1'b1;
        tick(4);
        push("R6 release keeps zero");
        latch_word("R6 shift data preserved through hold clear");

        // R8: tied strobes
        tied_pulse(1'b1, "R8 tied pulse one");
        tied_pulse(1'b0, "R8 tied pulse two");
        tied_pulse(1'b1, "R8 tied pulse three");

        // R9: latency from pin to output
        latch_word("R9 setup transfer");
        latch_clear_n = 1'b0;
        tick(2);
        push("R9 no change before third edge");
        tick(1);
        m_store = 8'h00;
        push("R9 change at third edge");
        latch_clear_n = 1'b1;
        tick(4);

        tick(3);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog (all requirements): run incomplete, expected finish before 20000 cycles");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule